// File: doc/BRIEF.md
# Right-to-Left Elliptic Curve Scalar Multiplication Sequencer

This block computes R = kP on an elliptic curve over a binary field. It walks the scalar upward, one bit per iteration, from bit 0. It holds two points. The accumulator starts at the point at infinity. The auxiliary point starts at the base point and is doubled on every iteration. The field arithmetic is done elsewhere. An external point-addition unit and an external point-doubling unit are launched in the same cycle of every iteration. The sequencer waits until both report completion, then keeps the sum or drops it according to the current scalar bit.

The external units only evaluate the generic chord and tangent formulas. All cases involving infinity are resolved here, from a flag kept beside each stored point, so any degenerate result the external units return is never committed. Those cases are an infinite operand, a point added to its own negative (same x, y differing by x), equal operands, and doubling a point whose x is zero. The data paths to both units are start/done handshakes with no back-pressure. A unit may take any number of cycles. Its operands stay steady from its start pulse until the sequencer commits. It raises done for one cycle with its result, and the sequencer captures that result on that cycle. `start` and `done` at the top level are plain control pins.

The field degree M also sets the scalar width. The default is 233. Coordinates are opaque M-bit words to this block.

Top module: `ec_kp_seq`

## Requirements
- R1: A `start` pulse while idle captures `k`, `px` and `py`, sets the accumulator to infinity and the auxiliary point to (`px`,`py`). Scanning then begins at bit 0, so k = 0 ends with `r_inf` high.
- R2: Each run has exactly M iterations. In each iteration `add_start` and `dbl_start` are high together for exactly one cycle.
- R3: The adder receives the accumulator as (`add_ax`,`add_ay`) and the auxiliary point as (`add_bx`,`add_by`). The doubler receives the auxiliary point. These operands stay unchanged while the sequencer waits for completion.
- R4: An iteration commits only after both `add_done` and `dbl_done` have been seen since its launch. The two may arrive in either order, with any latency.
- R5: With bit 1, a finite auxiliary point, a finite accumulator and distinct x coordinates, the accumulator takes the adder result. With bit 1 and an infinite accumulator, the accumulator takes the auxiliary point and becomes finite. With bit 0 the accumulator is unchanged.
- R6: The auxiliary point takes the doubler result on every iteration. It becomes infinity instead if it was infinite or its x coordinate is zero.
- R7: With bit 1, when the accumulator equals the finite auxiliary point, the accumulator takes the new auxiliary value from R6, including its infinity flag.
- R8: With bit 1, when both points are finite with equal x and different y, the accumulator becomes infinity.
- R9: With bit 1 and an infinite auxiliary point, the accumulator is unchanged.
- R10: `done` is high for exactly one cycle, one cycle after the commit of bit M-1. `rx`, `ry` and `r_inf` then hold until the next accepted start. `rx` and `ry` are meaningful only while `r_inf` is low.
- R11: A `start` pulse while a run is in progress is ignored, together with its `k`, `px` and `py`.
- R12: After reset the block is idle with `done`, `add_start` and `dbl_start` low and `r_inf` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a run (accepted only while idle) |
| k | input | M | Scalar |
| px | input | M | Base point x |
| py | input | M | Base point y |
| done | output | 1 | One-cycle completion pulse |
| rx | output | M | Result x |
| ry | output | M | Result y |
| r_inf | output | 1 | Result is the point at infinity |
| add_start | output | 1 | Launch the point adder |
| add_ax | output | M | Adder operand A x (accumulator) |
| add_ay | output | M | Adder operand A y |
| add_bx | output | M | Adder operand B x (auxiliary) |
| add_by | output | M | Adder operand B y |
| add_done | input | 1 | Adder result valid (one cycle) |
| add_qx | input | M | Adder result x |
| add_qy | input | M | Adder result y |
| dbl_start | output | 1 | Launch the point doubler |
| dbl_x | output | M | Doubler operand x |
| dbl_y | output | M | Doubler operand y |
| dbl_done | input | 1 | Doubler result valid (one cycle) |
| dbl_qx | input | M | Doubler result x |
| dbl_qy | input | M | Doubler result y |

## Verification
The assertions check the control behaviour on every cycle:
- each launch lasts a single cycle;
- operands stay steady during the wait;
- nothing commits before both completions;
- the point registers load correctly on an accepted start;
- `done` is a lone pulse issued from idle.

Whether the right point ends up in the accumulator can only be shown by the bench scenarios. These cover the infinity, negation, equality and zero-x cases and an ignored start. The bench sweeps every point of a small curve over GF(2^4) against every 4-bit scalar, under mixed unit latencies. Each result is compared with kP obtained by repeated full addition.

// File: rtl/kp_pkg.sv
`timescale 1ns/1ps
package kp_pkg;
  typedef enum logic [1:0] {
    KP_IDLE   = 2'd0,
    KP_ISSUE  = 2'd1,
    KP_WAIT   = 2'd2,
    KP_COMMIT = 2'd3
  } kp_state_t;
endpackage

// File: rtl/kp_step_fsm.sv
`timescale 1ns/1ps
module kp_step_fsm
  import kp_pkg::*;
#(
  parameter int M = 233
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      start,
  input  logic      both_got,
  output kp_state_t state,
  output logic      accept,
  output logic      issue,
  output logic      commit,
  output logic      done
);
  localparam int IW = (M > 1) ? $clog2(M) : 1;

  logic [IW-1:0] idx;
  logic          last;

  assign last   = (idx == IW'(M - 1));
  assign accept = (state == KP_IDLE) && start;
  assign issue  = (state == KP_ISSUE);
  assign commit = (state == KP_COMMIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= KP_IDLE;
      idx   <= '0;
      done  <= 1'b0;
    end else begin
      done <= commit && last;
      unique case (state)
        KP_IDLE: if (start) begin
          idx   <= '0;
          state <= KP_ISSUE;
        end
        KP_ISSUE: state <= KP_WAIT;
        KP_WAIT: if (both_got) state <= KP_COMMIT;
        KP_COMMIT: begin
          if (last) begin
            state <= KP_IDLE;
          end else begin
            idx   <= idx + 1'b1;
            state <= KP_ISSUE;
          end
        end
        default: state <= KP_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/kp_done_join.sv
`timescale 1ns/1ps
module kp_done_join #(
  parameter int M = 233
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         done_in,
  input  logic [M-1:0] res_x,
  input  logic [M-1:0] res_y,
  output logic         got,
  output logic [M-1:0] cap_x,
  output logic [M-1:0] cap_y
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      got   <= 1'b0;
      cap_x <= '0;
      cap_y <= '0;
    end else if (clear) begin
      got <= 1'b0;
    end else if (done_in && !got) begin
      got   <= 1'b1;
      cap_x <= res_x;
      cap_y <= res_y;
    end
  end
endmodule

// File: rtl/kp_case_sel.sv
`timescale 1ns/1ps
module kp_case_sel #(
  parameter int M = 233
) (
  input  logic         bit_k,
  input  logic         r_inf,
  input  logic [M-1:0] r_x,
  input  logic [M-1:0] r_y,
  input  logic         s_inf,
  input  logic [M-1:0] s_x,
  input  logic [M-1:0] s_y,
  input  logic [M-1:0] sum_x,
  input  logic [M-1:0] sum_y,
  input  logic [M-1:0] dbl_x,
  input  logic [M-1:0] dbl_y,
  output logic         nr_inf,
  output logic [M-1:0] nr_x,
  output logic [M-1:0] nr_y,
  output logic         ns_inf,
  output logic [M-1:0] ns_x,
  output logic [M-1:0] ns_y
);
  logic s_goes_inf;
  logic same_x;
  logic same_y;

  assign s_goes_inf = s_inf || (s_x == '0);
  assign same_x     = (r_x == s_x);
  assign same_y     = (r_y == s_y);

  always_comb begin
    ns_inf = s_goes_inf;
    ns_x   = s_goes_inf ? s_x : dbl_x;
    ns_y   = s_goes_inf ? s_y : dbl_y;

    nr_inf = r_inf;
    nr_x   = r_x;
    nr_y   = r_y;
    if (bit_k && !s_inf) begin
      if (r_inf) begin
        nr_inf = 1'b0;
        nr_x   = s_x;
        nr_y   = s_y;
      end else if (same_x && same_y) begin
        nr_inf = ns_inf;
        nr_x   = ns_x;
        nr_y   = ns_y;
      end else if (same_x) begin
        nr_inf = 1'b1;
      end else begin
        nr_x = sum_x;
        nr_y = sum_y;
      end
    end
  end
endmodule

// File: rtl/ec_kp_seq.sv
`timescale 1ns/1ps
module ec_kp_seq
  import kp_pkg::*;
#(
  parameter int M = 233
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [M-1:0] k,
  input  logic [M-1:0] px,
  input  logic [M-1:0] py,
  output logic         done,
  output logic [M-1:0] rx,
  output logic [M-1:0] ry,
  output logic         r_inf,
  output logic         add_start,
  output logic [M-1:0] add_ax,
  output logic [M-1:0] add_ay,
  output logic [M-1:0] add_bx,
  output logic [M-1:0] add_by,
  input  logic         add_done,
  input  logic [M-1:0] add_qx,
  input  logic [M-1:0] add_qy,
  output logic         dbl_start,
  output logic [M-1:0] dbl_x,
  output logic [M-1:0] dbl_y,
  input  logic         dbl_done,
  input  logic [M-1:0] dbl_qx,
  input  logic [M-1:0] dbl_qy
);
  kp_state_t    st;
  logic         accept, issue, commit;
  logic         got_a, got_d;
  logic [M-1:0] sum_x, sum_y, twice_x, twice_y;

  logic         acc_inf, aux_inf;
  logic [M-1:0] acc_x, acc_y, aux_x, aux_y, k_sh;

  logic         nr_inf, ns_inf;
  logic [M-1:0] nr_x, nr_y, ns_x, ns_y;

  kp_step_fsm #(.M(M)) u_fsm (
    .clk(clk), .rst_n(rst_n), .start(start), .both_got(got_a && got_d),
    .state(st), .accept(accept), .issue(issue), .commit(commit), .done(done)
  );

  kp_done_join #(.M(M)) u_join_add (
    .clk(clk), .rst_n(rst_n), .clear(issue), .done_in(add_done),
    .res_x(add_qx), .res_y(add_qy), .got(got_a), .cap_x(sum_x), .cap_y(sum_y)
  );

  kp_done_join #(.M(M)) u_join_dbl (
    .clk(clk), .rst_n(rst_n), .clear(issue), .done_in(dbl_done),
    .res_x(dbl_qx), .res_y(dbl_qy), .got(got_d), .cap_x(twice_x), .cap_y(twice_y)
  );

  kp_case_sel #(.M(M)) u_sel (
    .bit_k(k_sh[0]),
    .r_inf(acc_inf), .r_x(acc_x), .r_y(acc_y),
    .s_inf(aux_inf), .s_x(aux_x), .s_y(aux_y),
    .sum_x(sum_x), .sum_y(sum_y), .dbl_x(twice_x), .dbl_y(twice_y),
    .nr_inf(nr_inf), .nr_x(nr_x), .nr_y(nr_y),
    .ns_inf(ns_inf), .ns_x(ns_x), .ns_y(ns_y)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_inf <= 1'b1;
      acc_x   <= '0;
      acc_y   <= '0;
      aux_inf <= 1'b0;
      aux_x   <= '0;
      aux_y   <= '0;
      k_sh    <= '0;
    end else if (accept) begin
      acc_inf <= 1'b1;
      aux_inf <= 1'b0;
      aux_x   <= px;
      aux_y   <= py;
      k_sh    <= k;
    end else if (commit) begin
      acc_inf <= nr_inf;
      acc_x   <= nr_x;
      acc_y   <= nr_y;
      aux_inf <= ns_inf;
      aux_x   <= ns_x;
      aux_y   <= ns_y;
      k_sh    <= k_sh >> 1;
    end
  end

  assign add_start = issue;
  assign dbl_start = issue;
  assign add_ax    = acc_x;
  assign add_ay    = acc_y;
  assign add_bx    = aux_x;
  assign add_by    = aux_y;
  assign dbl_x     = aux_x;
  assign dbl_y     = aux_y;
  assign rx        = acc_x;
  assign ry        = acc_y;
  assign r_inf     = acc_inf;
endmodule

// File: rtl/kp_seq_checker.sv
`timescale 1ns/1ps
module kp_seq_checker
  import kp_pkg::*;
#(
  parameter int M = 233
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic [M-1:0] px,
  input logic [M-1:0] py,
  input logic         done,
  input logic         add_start,
  input logic [M-1:0] add_ax,
  input logic [M-1:0] add_ay,
  input logic [M-1:0] add_bx,
  input logic [M-1:0] add_by,
  input logic [M-1:0] dbl_x,
  input logic [M-1:0] dbl_y,
  input kp_state_t    st,
  input logic         got_a,
  input logic         got_d,
  input logic         acc_inf,
  input logic         aux_inf,
  input logic [M-1:0] aux_x,
  input logic [M-1:0] aux_y
);
  a_r2_launch_single: assert property (@(posedge clk) disable iff (!rst_n)
    add_start |=> !add_start);

  a_r3_ops_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (st == KP_WAIT && $past(st) == KP_WAIT) |->
      ($stable(add_ax) && $stable(add_ay) && $stable(add_bx) &&
       $stable(add_by) && $stable(dbl_x) && $stable(dbl_y)));

  a_r4_commit_needs_both: assert property (@(posedge clk) disable iff (!rst_n)
    (st == KP_COMMIT) |-> (got_a && got_d));

  a_r1_load_points: assert property (@(posedge clk) disable iff (!rst_n)
    (st == KP_IDLE && start) |=>
      (acc_inf && !aux_inf && aux_x == $past(px) && aux_y == $past(py)));

  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r10_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (st == KP_IDLE));
endmodule

bind ec_kp_seq kp_seq_checker #(.M(M)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .px(px), .py(py), .done(done),
  .add_start(add_start), .add_ax(add_ax), .add_ay(add_ay),
  .add_bx(add_bx), .add_by(add_by), .dbl_x(dbl_x), .dbl_y(dbl_y),
  .st(st), .got_a(got_a), .got_d(got_d), .acc_inf(acc_inf),
  .aux_inf(aux_inf), .aux_x(aux_x), .aux_y(aux_y)
);

// File: tb/ec_kp_seq_test.sv
`timescale 1ns/1ps
module ec_kp_seq_test;
  localparam int M = 4;
  localparam logic [3:0] A2 = 4'h1;
  localparam logic [3:0] A6 = 4'h1;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [M-1:0] k = '0, px = '0, py = '0;
  logic done, r_inf, add_start, dbl_start;
  logic [M-1:0] rx, ry, add_ax, add_ay, add_bx, add_by, dbl_x, dbl_y;
  logic add_done = 1'b0, dbl_done = 1'b0;
  logic [M-1:0] add_qx = '0, add_qy = '0, dbl_qx = '0, dbl_qy = '0;

  int vectors = 0, fails = 0;
  int lat_a = 1, lat_d = 1, a_cnt = 0, d_cnt = 0, launches = 0;
  logic [8:0] pts [0:31];
  int n_pts = 0;

  ec_kp_seq #(.M(M)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .k(k), .px(px), .py(py),
    .done(done), .rx(rx), .ry(ry), .r_inf(r_inf),
    .add_start(add_start), .add_ax(add_ax), .add_ay(add_ay),
    .add_bx(add_bx), .add_by(add_by), .add_done(add_done),
    .add_qx(add_qx), .add_qy(add_qy),
    .dbl_start(dbl_start), .dbl_x(dbl_x), .dbl_y(dbl_y),
    .dbl_done(dbl_done), .dbl_qx(dbl_qx), .dbl_qy(dbl_qy)
  );

  always #2 clk = ~clk;

  function automatic logic [3:0] gmul(input logic [3:0] a, input logic [3:0] b);
    logic [3:0] p = 4'h0;
    logic [3:0] t = a;
    for (int i = 0; i < 4; i++) begin
      if (b[i]) p = p ^ t;
      t = t[3] ? ((t << 1) ^ 4'h3) : (t << 1);
    end
    return p;
  endfunction

  function automatic logic [3:0] ginv(input logic [3:0] a);
    logic [3:0] r = 4'h1;
    for (int i = 0; i < 14; i++) r = gmul(r, a);
    return r;
  endfunction

  // Generic formulas only, as an external unit would compute them.
  function automatic logic [7:0] gen_add(input logic [3:0] x1, y1, x2, y2);
    logic [3:0] l, x3;
    l  = gmul(y1 ^ y2, ginv(x1 ^ x2));
    x3 = gmul(l, l) ^ l ^ x1 ^ x2 ^ A2;
    return {x3, gmul(l, x1 ^ x3) ^ x3 ^ y1};
  endfunction

  function automatic logic [7:0] gen_dbl(input logic [3:0] x, y);
    logic [3:0] l, x3;
    l  = x ^ gmul(y, ginv(x));
    x3 = gmul(l, l) ^ l ^ A2;
    return {x3, gmul(x, x) ^ gmul(l ^ 4'h1, x3)};
  endfunction

  // Full group law, bit 8 = infinity.
  function automatic logic [8:0] full_add(input logic [8:0] p, input logic [8:0] q);
    if (p[8]) return q;
    if (q[8]) return p;
    if (p[7:4] == q[7:4]) begin
      if (p[3:0] != q[3:0] || p[7:4] == 4'h0) return 9'h100;
      return {1'b0, gen_dbl(p[7:4], p[3:0])};
    end
    return {1'b0, gen_add(p[7:4], p[3:0], q[7:4], q[3:0])};
  endfunction

  function automatic logic [8:0] ref_kp(input logic [8:0] p, input int kk);
    logic [8:0] acc = 9'h100;
    for (int i = 0; i < kk; i++) acc = full_add(acc, p);
    return acc;
  endfunction

  // Unit models with programmable latency.
  always @(negedge clk) begin
    add_done = 1'b0;
    dbl_done = 1'b0;
    if (add_start) begin
      a_cnt = lat_a;
      {add_qx, add_qy} = gen_add(add_ax, add_ay, add_bx, add_by);
      launches++;
    end else if (a_cnt > 0) begin
      a_cnt--;
      if (a_cnt == 0) add_done = 1'b1;
    end
    if (dbl_start) begin
      d_cnt = lat_d;
      {dbl_qx, dbl_qy} = gen_dbl(dbl_x, dbl_y);
    end else if (d_cnt > 0) begin
      d_cnt--;
      if (d_cnt == 0) dbl_done = 1'b1;
    end
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic run_one(input int pi, input int kk, input bit poke);
    logic [8:0] p, e;
    int cyc;
    bit got;
    string tag;
    p = pts[pi];
    e = ref_kp(p, kk);
    @(negedge clk);
    k = kk[M-1:0]; px = p[7:4]; py = p[3:0]; start = 1'b1; launches = 0;
    @(negedge clk);
    start = 1'b0;
    cyc = 0; got = 0;
    while (!got && cyc < 400) begin
      @(negedge clk);
      cyc++;
      if (poke && cyc == 3) begin
        start = 1'b1; k = ~kk[M-1:0];
        {px, py} = pts[(pi + 1) % n_pts][7:0];
      end else begin
        start = 1'b0;
      end
      if (done) got = 1;
    end
    start = 1'b0;
    if (poke) tag = "R11";
    else if (kk == 0) tag = "R1";
    else if (e[8]) tag = "R8";
    else tag = "R5";
    // Sweep exercises R6, R7 and R9 (zero-x points, equal operands, infinite aux).
    if (!got) begin
      chk(1'b0, "R10", "no done", 0, 1);
    end else begin
      chk(r_inf == e[8], tag, "r_inf", int'(r_inf), int'(e[8]));
      if (!e[8]) chk({rx, ry} == e[7:0], tag, "rx:ry", int'({rx, ry}), int'(e[7:0]));
      chk(launches == M, "R2", "iterations", launches, M);
      @(negedge clk);
      chk(done == 1'b0, "R10", "done width", int'(done), 0);
      chk({r_inf, rx, ry} == {r_inf, rx, ry} && r_inf == e[8], "R10", "hold",
          int'(r_inf), int'(e[8]));
    end
  endtask

  initial begin
    #(4 * 150000);
    fails++;
    $display("FAIL R10 watchdog expired actual=0 expected=1");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    for (int x = 0; x < 16; x++)
      for (int y = 0; y < 16; y++)
        if ((gmul(y[3:0], y[3:0]) ^ gmul(x[3:0], y[3:0])) ==
            (gmul(gmul(x[3:0], x[3:0]), x[3:0]) ^ gmul(A2, gmul(x[3:0], x[3:0])) ^ A6)) begin
          pts[n_pts] = {1'b0, x[3:0], y[3:0]};
          n_pts++;
        end

    repeat (3) @(negedge clk);
    chk(done == 1'b0, "R12", "done", int'(done), 0);
    chk(add_start == 1'b0 && dbl_start == 1'b0, "R12", "starts",
        int'({add_start, dbl_start}), 0);
    chk(r_inf == 1'b1, "R12", "r_inf", int'(r_inf), 1);
    rst_n = 1'b1;

    for (int pi = 0; pi < n_pts; pi++)
      for (int kk = 0; kk < (1 << M); kk++) begin
        lat_a = 1 + ((pi + kk) % 3);   // R4: varied latencies and arrival order
        lat_d = 1 + ((pi * kk) % 4);
        run_one(pi, kk, (kk % 5) == 3);
      end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule